// File: doc/BRIEF.md
# Gnome-Order Byte Sorter

This block reorders a fixed set of 32 unsigned bytes held in its own register array so that they end up in ascending order. A host fills the array through a write port while the engine is idle. It then pulses `start` and waits for `done`. After that it reads the sorted bytes back one address at a time through a combinational read port. Address 0 holds the smallest value.

The sort walks a single position pointer along the array. At each step it looks at the byte under the pointer and the byte just after it. If that pair is already in order, the pointer moves forward. If it is not, the two bytes trade places and the pointer moves back one slot, but it never goes below the first slot. The run ends when the pointer lands on the final slot. A compare and a swap each take one clock, so the run length follows directly from the input data.

Top module: `gnome_sort_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and every array entry reads back as 0.
- R2: While `busy` is low, a cycle with `wr_en` high stores `wr_data` at `wr_addr`. `rd_data` always shows the entry selected by `rd_addr` in the same cycle, with no register delay.
- R3: A `start` pulse seen while `busy` is low launches a run. On the next cycle `busy` is high, `done` is low, and the pointer is at position 0.
- R4: While `busy` is high, `wr_en` and `start` are ignored. Array contents, the run length and the result are exactly as if neither had been asserted.
- R5: Bytes are compared as unsigned 8-bit values. A pair counts as in order when the later byte is greater than or equal to the earlier one, so equal neighbours are never exchanged.
- R6: An in-order compare takes one clock and moves the pointer forward by one.
- R7: An out-of-order compare is followed by one swap clock that exchanges the two bytes. The pointer then drops back by one, except at position 0, where it stays.
- R8: The run ends when a compare step finds the pointer at position 31. `done` rises on that clock, so the run takes (compares + swaps + 1) clocks after the accepting edge.
- R9: `done` and `busy` are never high together. `done` stays high until the next accepted `start`.
- R10: At the end of a run, the array holds the original bytes in ascending unsigned order from address 0 to address 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Array write strobe, honoured only while idle |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| start | input | 1 | Launch pulse, honoured only while idle |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Combinational read data |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High from the end of a run until the next accepted start |

## Verification
The bench builds the block with its default parameters: 32 entries of 8 bits. With that size a reverse-ordered load reaches the largest possible swap count, 496, and the clamp at position 0 is hit many times. For each load, the bench replays the pointer walk in a small model to predict the exact clock on which `done` rises. It then compares the readback against a plain sorted copy. The loads are: all equal, already ascending, reverse, values that straddle 0x80, and seeded random vectors. One run injects a write and a second start mid-sort.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_CMP  = 2'd1,
    GS_SWP  = 2'd2
  } gs_state_e;
endpackage

// File: rtl/gs_rst_sync.sv
module gs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gs_cmp.sv
module gs_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lo_val,
  input  logic [DATA_W-1:0] hi_val,
  output logic              in_order
);
  // unsigned: later element must not be smaller than the earlier one
  assign in_order = (hi_val >= lo_val);
endmodule

// File: rtl/gs_array.sv
module gs_array #(
  parameter int N_ELEM = 32,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(N_ELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              swap_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] cur_val,
  output logic [DATA_W-1:0] nxt_val
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ELEM - 1);

  logic [DATA_W-1:0] mem_q [N_ELEM];
  logic [DATA_W-1:0] mem_d [N_ELEM];
  logic [IDX_W-1:0]  idx_nx;

  assign idx_nx  = (idx == LAST_IDX) ? idx : idx + 1'b1;
  assign cur_val = mem_q[idx];
  assign nxt_val = mem_q[idx_nx];
  assign rd_data = mem_q[rd_addr];

  for (genvar g = 0; g < N_ELEM; g++) begin : g_cell
    logic hit_lo, hit_hi, hit_wr, cell_en;

    assign hit_lo  = swap_en && (idx == IDX_W'(g));
    assign hit_hi  = swap_en && (idx != LAST_IDX) && (idx_nx == IDX_W'(g));
    assign hit_wr  = wr_en && (wr_addr == IDX_W'(g));
    assign cell_en = hit_lo || hit_hi || hit_wr;

    always_comb begin
      mem_d[g] = mem_q[g];
      if (hit_lo)      mem_d[g] = nxt_val;
      else if (hit_hi) mem_d[g] = cur_val;
      else if (hit_wr) mem_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[g] <= '0;
      else if (cell_en) mem_q[g] <= mem_d[g];
    end
  end
endmodule

// File: rtl/gs_ctrl.sv
module gs_ctrl #(
  parameter int N_ELEM = 32,
  localparam int IDX_W = $clog2(N_ELEM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                in_order,
  output gs_pkg::gs_state_e   state,
  output logic [IDX_W-1:0]    idx,
  output logic                swap_en,
  output logic                busy,
  output logic                done
);
  import gs_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ELEM - 1);

  gs_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             idx_en;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = done_q;
    unique case (state_q)
      GS_IDLE: begin
        if (start) begin
          state_d = GS_CMP;
          idx_d   = '0;
          done_d  = 1'b0;
        end
      end
      GS_CMP: begin
        if (idx_q == LAST_IDX) begin
          state_d = GS_IDLE;
          done_d  = 1'b1;
        end else if (in_order) begin
          idx_d = idx_q + 1'b1;
        end else begin
          state_d = GS_SWP;
        end
      end
      GS_SWP: begin
        state_d = GS_CMP;
        idx_d   = (idx_q == '0) ? '0 : idx_q - 1'b1;
      end
      default: state_d = GS_IDLE;
    endcase
  end

  assign idx_en = (state_q != GS_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign state   = state_q;
  assign idx     = idx_q;
  assign swap_en = (state_q == GS_SWP);
  assign busy    = (state_q != GS_IDLE);
  assign done    = done_q;
endmodule

// File: rtl/gnome_sort_engine.sv
module gnome_sort_engine #(
  parameter int N_ELEM = 32,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(N_ELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);
  logic              rst_sync_n;
  logic              wr_ok;
  logic              swap_en;
  logic              in_order;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] cur_val, nxt_val;
  gs_pkg::gs_state_e state;

  gs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign wr_ok = wr_en && !busy;

  gs_array #(.N_ELEM(N_ELEM), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_ok), .wr_addr(wr_addr), .wr_data(wr_data),
    .swap_en(swap_en), .idx(idx), .rd_addr(rd_addr),
    .rd_data(rd_data), .cur_val(cur_val), .nxt_val(nxt_val)
  );

  gs_cmp #(.DATA_W(DATA_W)) u_cmp (
    .lo_val(cur_val), .hi_val(nxt_val), .in_order(in_order)
  );

  gs_ctrl #(.N_ELEM(N_ELEM)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .in_order(in_order),
    .state(state), .idx(idx), .swap_en(swap_en), .busy(busy), .done(done)
  );
endmodule

// File: rtl/gnome_sort_engine_chk.sv
module gnome_sort_engine_chk #(
  parameter int N_ELEM = 32,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(N_ELEM)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input gs_pkg::gs_state_e state,
  input logic [IDX_W-1:0]  idx,
  input logic [DATA_W-1:0] cur_val,
  input logic [DATA_W-1:0] nxt_val
);
  import gs_pkg::*;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ELEM - 1);

  a_r9_done_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && idx == '0));

  a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_CMP && idx != LAST_IDX && nxt_val >= cur_val)
      |=> (state == GS_CMP && idx == IDX_W'($past(idx) + 1'b1)));

  a_r5_swap_on_inversion: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_CMP && idx != LAST_IDX && nxt_val < cur_val) |=> (state == GS_SWP));

  a_r7_step_back: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_SWP) |=> (state == GS_CMP &&
      idx == (($past(idx) == '0) ? '0 : IDX_W'($past(idx) - 1'b1))));

  a_r8_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GS_CMP && idx == LAST_IDX) |=> (done && !busy));
endmodule

bind gnome_sort_engine gnome_sort_engine_chk #(.N_ELEM(N_ELEM), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .busy(busy), .done(done),
  .state(state), .idx(idx), .cur_val(cur_val), .nxt_val(nxt_val)
);

// File: tb/gnome_sort_engine_bench.sv
module gnome_sort_engine_bench;
  localparam int CLK_P = 10;
  localparam int N = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       start = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, done;

  int checks = 0;
  int errors = 0;
  logic [7:0] vec [N];
  logic [7:0] exp_sorted [N];

  always #(CLK_P/2) clk = ~clk;

  gnome_sort_engine u_gnome_sort_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Model of the pointer walk: returns compare+swap steps, fills exp_sorted
  function automatic int model_steps();
    logic [7:0] a [N];
    logic [7:0] t;
    int p = 0;
    int steps = 0;
    for (int i = 0; i < N; i++) a[i] = vec[i];
    while (p != N-1) begin
      steps++;
      if (a[p+1] >= a[p]) p++;
      else begin
        t = a[p]; a[p] = a[p+1]; a[p+1] = t;
        steps++;
        if (p != 0) p--;
      end
    end
    for (int i = 0; i < N; i++) exp_sorted[i] = a[i];
    return steps;
  endfunction

  task automatic load_vec();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(i); wr_data = vec[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic readback(input string req);
    int bad = 0;
    for (int i = 0; i < N; i++) begin
      rd_addr = 5'(i);
      #1;
      if (rd_data !== exp_sorted[i]) begin
        bad++;
        if (bad == 1) chk(1'b0, req, int'(rd_data), int'(exp_sorted[i]));
      end
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
  endtask

  task automatic run_sort(input string name, input bit inject);
    int exp_cyc = model_steps() + 1;
    int cnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, {"R3 launch ", name}, int'(busy), 1);
    while (!done && cnt < 4000) begin
      @(negedge clk);
      cnt++;
      if (inject && cnt == 3) begin
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 8'hFF; start = 1'b1;
      end else if (inject && cnt == 4) begin
        wr_en = 1'b0; start = 1'b0;
      end
      if (busy && done) chk(1'b0, {"R9 busy+done ", name}, 1, 0);
    end
    // R8: exact run length; R4 when injected
    chk(cnt == exp_cyc, {inject ? "R4 length " : "R8 length ", name}, cnt, exp_cyc);
    readback({inject ? "R4 result " : "R10 result ", name});
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R1 flags after reset", int'({busy, done}), 0);
    rd_addr = 5'd0;  #1; chk(rd_data == 8'h00, "R1 entry0", int'(rd_data), 0);
    rd_addr = 5'd31; #1; chk(rd_data == 8'h00, "R1 entry31", int'(rd_data), 0);
  endtask

  task automatic t_load_read();
    for (int i = 0; i < N; i++) vec[i] = 8'(i * 7 + 3);
    load_vec();
    rd_addr = 5'd5;  #1; chk(rd_data == 8'd38,  "R2 read 5", int'(rd_data), 38);
    rd_addr = 5'd30; #1; chk(rd_data == 8'd213, "R2 read 30", int'(rd_data), 213);
  endtask

  task automatic t_equal();
    for (int i = 0; i < N; i++) vec[i] = 8'h5A;
    load_vec();
    run_sort("R5 all-equal", 1'b0);
  endtask

  task automatic t_sorted();
    for (int i = 0; i < N; i++) vec[i] = 8'(i * 5);
    load_vec();
    run_sort("R6 ascending", 1'b0);
  endtask

  task automatic t_reverse();
    for (int i = 0; i < N; i++) vec[i] = 8'(250 - i * 7);
    load_vec();
    run_sort("R7 reverse", 1'b0);
  endtask

  task automatic t_unsigned();
    for (int i = 0; i < N; i++) vec[i] = (i % 2 == 0) ? 8'(8'h80 + i) : 8'(8'h7F - i);
    vec[3] = 8'hFF; vec[10] = 8'h00;
    load_vec();
    run_sort("R5 straddle 0x80", 1'b0);
  endtask

  task automatic t_random();
    void'($urandom(32'h1234));
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < N; i++) vec[i] = 8'($urandom);
      load_vec();
      run_sort("R10 random", 1'b0);
    end
  endtask

  task automatic t_busy_ignore();
    for (int i = 0; i < N; i++) vec[i] = 8'(i * 37 + 11);
    load_vec();
    run_sort("busy inject", 1'b1);
  endtask

  task automatic t_done_hold();
    repeat (5) @(negedge clk);
    chk(done && !busy, "R9 done held", int'(done), 1);
    // array already sorted; a new run clears done then walks forward only
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R9 done cleared by start", int'(done), 0);
    repeat (N) @(negedge clk);
    chk(done, "R8 rerun on sorted data", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_read();
    t_equal();
    t_sorted();
    t_reverse();
    t_unsigned();
    t_random();
    t_busy_ignore();
    t_done_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule